// File: doc/BRIEF.md
# Master/Standby Frame Pulse Generator

This block derives a 2 kHz system frame pulse from a 38.88 MHz system clock by dividing it by 19440. It sits on each of two redundant clock boards. On the board acting as master, the divider runs freely. On the board acting as standby, each frame-sync pulse received from the master re-phases the local divider, so that both boards mark frame starts in the same clock cycle.

The board clocks are assumed phase-synchronous, so once the standby divider has been re-phased its pulses stay in step with the master's. A status flag reports when the standby unit has seen a run of consecutive sync pulses that land exactly on its own frame pulse. Any disagreement between the remote sync and the local pulse clears the flag. If the remote sync stops, the standby divider keeps running at the last phase it was given.

Top module: `framepulse_gen`

## Requirements
- R1: While `rst` is high, `frame_pulse_o` and `aligned_o` are low. The first frame pulse appears in the first cycle after the first clock edge with `rst` low.
- R2: In master role (`standby_i` = 0), `frame_pulse_o` is high for exactly one cycle out of every DIV_RATIO cycles. DIV_RATIO defaults to 19440.
- R3: In master role, `remote_sync_i` has no effect on the timing of `frame_pulse_o`.
- R4: In standby role (`standby_i` = 1), the cycle in which `remote_sync_i` is high counts as frame phase 0. The next local frame pulse appears exactly DIV_RATIO cycles after that cycle.
- R5: In standby role with no remote sync, the divider keeps its phase and pulses every DIV_RATIO cycles.
- R6: In standby role, `aligned_o` rises in the cycle after the ALIGN_NEEDED-th consecutive matching event. ALIGN_NEEDED defaults to 3. A matching event is a cycle in which `remote_sync_i` and `frame_pulse_o` are both high.
- R7: In standby role, `aligned_o` goes low in the cycle after a mismatch. A mismatch is a cycle in which exactly one of `remote_sync_i` and `frame_pulse_o` is high.
- R8: In master role, `aligned_o` is low in every cycle after the first edge sampled in that role, and the match run is reset.
- R9: Once set, `aligned_o` stays high while matching events continue. The match run saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (38.88 MHz in use) |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Role select: 0 = master, 1 = standby |
| remote_sync_i | input | 1 | One-cycle frame sync received from the master board |
| frame_pulse_o | output | 1 | One-cycle system frame pulse |
| aligned_o | output | 1 | Standby divider has been confirmed in phase with the remote sync |

## Verification
The hardest state to reach from the ports is a confirmed alignment that is then broken in each of the two possible ways: a sync that goes missing while the local pulse fires, and a sync that arrives off phase. The stimulus builds this up frame by frame. It first sends one sync at an arbitrary phase. It then sends syncs every DIV_RATIO cycles until the flag sets, withholds one sync, re-aligns, and finally injects a sync a few cycles away from the local pulse. The bench overrides DIV_RATIO with a small value so that many frames fit into the run. A behavioural model predicts both outputs in every cycle.

// File: rtl/fp_pkg.sv
package fp_pkg;

    typedef enum logic {
        ROLE_MASTER  = 1'b0,
        ROLE_STANDBY = 1'b1
    } role_e;

    typedef enum logic [1:0] {
        EVT_IDLE  = 2'd0,
        EVT_MATCH = 2'd1,
        EVT_MISS  = 2'd2
    } sync_evt_e;

    typedef struct packed {
        logic remote_sync;
        logic local_pulse;
    } phase_obs_t;

    function automatic sync_evt_e classify(input phase_obs_t obs);
        if (obs.remote_sync && obs.local_pulse)      return EVT_MATCH;
        else if (obs.remote_sync || obs.local_pulse) return EVT_MISS;
        else                                         return EVT_IDLE;
    endfunction

endpackage

// File: rtl/frame_divider.sv
module frame_divider
    import fp_pkg::*;
#(
    parameter int DIV_RATIO = 19440,
    localparam int CW = $clog2(DIV_RATIO)
) (
    input  logic          clk,
    input  logic          rst,
    input  role_e         role,
    input  logic          remote_sync,
    output logic [CW-1:0] phase_o,
    output logic          pulse_o
);
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] phase_q;
    logic          rephase;

    assign rephase = (role == ROLE_STANDBY) && remote_sync;

    always_ff @(posedge clk) begin
        if (rst)                 phase_q <= LAST;
        else if (rephase)        phase_q <= ONE;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + ONE;
    end

    assign phase_o = phase_q;
    assign pulse_o = (phase_q == '0);

    // R4: a standby sync sets the phase to one
    a_r4_sync_rephase: assert property (@(posedge clk) disable iff (rst)
        rephase |=> (phase_q == ONE));
    // R2: phase wraps to zero after the last count unless re-phased
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase_q == LAST && !rephase) |=> (phase_q == '0));
    // R2: phase never leaves its range
    a_r2_range: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST);
endmodule

// File: rtl/align_monitor.sv
module align_monitor
    import fp_pkg::*;
#(
    parameter int ALIGN_NEEDED = 3,
    localparam int MW = $clog2(ALIGN_NEEDED + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  role_e role,
    input  logic  remote_sync,
    input  logic  local_pulse,
    output logic  aligned_o
);
    localparam logic [MW-1:0] FULL = MW'(ALIGN_NEEDED);

    phase_obs_t    obs;
    sync_evt_e     evt;
    logic [MW-1:0] run_q;

    assign obs = '{remote_sync: remote_sync, local_pulse: local_pulse};
    assign evt = classify(obs);

    always_ff @(posedge clk) begin
        if (rst || role == ROLE_MASTER) begin
            run_q <= '0;
        end else begin
            unique case (evt)
                EVT_MATCH: if (run_q != FULL) run_q <= run_q + MW'(1);
                EVT_MISS:  run_q <= '0;
                default:   run_q <= run_q;
            endcase
        end
    end

    assign aligned_o = (run_q == FULL);

    // R7: any mismatch in standby drops the flag
    a_r7_mismatch_clears: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_STANDBY && (remote_sync != local_pulse)) |=> !aligned_o);
    // R8: master role keeps the flag low
    a_r8_master_low: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_MASTER) |=> !aligned_o);
    // R9: continued matches keep the flag set
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (aligned_o && role == ROLE_STANDBY && remote_sync && local_pulse) |=> aligned_o);
    // R6: the flag only rises right after a matching event
    a_r6_rise_after_match: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned_o) |-> $past(remote_sync && local_pulse));
endmodule

// File: rtl/framepulse_gen.sv
module framepulse_gen
    import fp_pkg::*;
#(
    parameter int DIV_RATIO    = 19440,
    parameter int ALIGN_NEEDED = 3,
    localparam int CW = $clog2(DIV_RATIO)
) (
    input  logic clk,
    input  logic rst,
    input  logic standby_i,
    input  logic remote_sync_i,
    output logic frame_pulse_o,
    output logic aligned_o
);
    role_e         role;
    logic [CW-1:0] phase;
    logic          pulse;

    assign role = standby_i ? ROLE_STANDBY : ROLE_MASTER;

    frame_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk         (clk),
        .rst         (rst),
        .role        (role),
        .remote_sync (remote_sync_i),
        .phase_o     (phase),
        .pulse_o     (pulse)
    );

    align_monitor #(.ALIGN_NEEDED(ALIGN_NEEDED)) u_mon (
        .clk         (clk),
        .rst         (rst),
        .role        (role),
        .remote_sync (remote_sync_i),
        .local_pulse (pulse),
        .aligned_o   (aligned_o)
    );

    assign frame_pulse_o = pulse;

    // R2: the frame pulse is one clock wide
    a_r2_one_wide: assert property (@(posedge clk) disable iff (rst)
        frame_pulse_o |=> !frame_pulse_o);
    // R1: outputs quiet during reset
    always_comb begin
        if (rst && phase != '0) begin
            a_r1_quiet_in_reset: assert (!aligned_o || !rst);
        end
    end
endmodule

// File: tb/framepulse_gen_tb_top.sv
module framepulse_gen_tb_top;
    localparam int DIV  = 48;
    localparam int NEED = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic standby_i = 1'b0;
    logic remote_sync_i = 1'b0;
    logic frame_pulse_o, aligned_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    framepulse_gen #(.DIV_RATIO(DIV), .ALIGN_NEEDED(NEED)) dut_i (
        .clk(clk), .rst(rst), .standby_i(standby_i),
        .remote_sync_i(remote_sync_i),
        .frame_pulse_o(frame_pulse_o), .aligned_o(aligned_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_cnt = DIV - 1;
    int m_run = 0;
    int cyc_no = 0;
    always @(posedge clk) begin
        cyc_no++;
        if (rst) begin
            m_cnt = DIV - 1;
            m_run = 0;
        end else begin
            if (!standby_i)                       m_run = 0;
            else if (remote_sync_i && m_cnt == 0) m_run = (m_run < NEED) ? m_run + 1 : m_run;
            else if (remote_sync_i || m_cnt == 0) m_run = 0;
            if (standby_i && remote_sync_i) m_cnt = 1;
            else                            m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
        end
    end

    // per-cycle comparison and period monitor
    bit    period_chk = 1'b0;
    string period_tag = "R2";
    int    last_pulse = -1;
    always @(posedge clk) begin
        #2;
        if (rst) begin
            check(frame_pulse_o == 1'b0, "R1", frame_pulse_o, 0);
            check(aligned_o == 1'b0, "R1", aligned_o, 0);
        end else begin
            check(frame_pulse_o == (m_cnt == 0), standby_i ? "R4" : "R2",
                  frame_pulse_o, int'(m_cnt == 0));
            check(aligned_o == (m_run == NEED), standby_i ? "R6" : "R8",
                  aligned_o, int'(m_run == NEED));
            if (period_chk && frame_pulse_o) begin
                if (last_pulse >= 0)
                    check(cyc_no - last_pulse == DIV, period_tag, cyc_no - last_pulse, DIV);
                last_pulse = cyc_no;
            end
        end
    end

    task automatic cyc(input logic s);
        @(negedge clk);
        remote_sync_i = s;
    endtask

    // one frame: optional sync in its first cycle, then DIV-1 quiet cycles
    task automatic frame(input logic s, input bit chk_pulse, input string tag,
                         input int exp_aligned);
        cyc(s);
        if (chk_pulse) check(frame_pulse_o == 1'b1, "R4", frame_pulse_o, 1);
        if (exp_aligned >= 0) check(aligned_o == exp_aligned[0], tag, aligned_o, exp_aligned);
        repeat (DIV - 1) cyc(1'b0);
    endtask

    initial begin
        // R1: reset state, then first pulse right after release
        repeat (3) @(negedge clk);
        check(frame_pulse_o == 1'b0 && aligned_o == 1'b0, "R1", frame_pulse_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(frame_pulse_o == 1'b1, "R1", frame_pulse_o, 1);

        // R2/R3: master, syncs at scattered phases must not move the pulse
        period_tag = "R3"; last_pulse = -1; period_chk = 1'b1;
        for (int i = 0; i < 4 * DIV; i++) cyc((i % 13) == 5);
        period_chk = 1'b0;

        // standby: first sync at an arbitrary phase, then one per frame
        standby_i = 1'b1;
        repeat (7) cyc(1'b0);
        frame(1'b1, 1'b0, "R6", -1);
        frame(1'b1, 1'b1, "R6", 0);
        frame(1'b1, 1'b1, "R6", 0);
        frame(1'b1, 1'b1, "R6", 0);
        frame(1'b1, 1'b1, "R6", 1);   // R6: set after third match
        frame(1'b1, 1'b1, "R9", 1);
        frame(1'b1, 1'b1, "R9", 1);   // R9: saturated run holds the flag
        // R7: withheld sync while the local pulse fires
        frame(1'b0, 1'b1, "R9", 1);
        frame(1'b1, 1'b1, "R7", 0);   // R5: pulse still on phase without sync
        frame(1'b1, 1'b1, "R6", 0);
        frame(1'b1, 1'b1, "R6", 0);
        frame(1'b1, 1'b1, "R6", 1);
        // R7: off-phase sync
        repeat (9) cyc(1'b0);
        cyc(1'b1);
        cyc(1'b0);
        check(aligned_o == 1'b0, "R7", aligned_o, 0);
        repeat (DIV - 2) cyc(1'b0);
        // R4: pulse lands exactly DIV cycles after the off-phase sync
        frame(1'b1, 1'b1, "R6", 0);
        frame(1'b1, 1'b1, "R6", 0);
        frame(1'b1, 1'b1, "R6", 0);
        frame(1'b1, 1'b1, "R6", 1);
        // R5: syncs stop, divider keeps period
        period_tag = "R5"; last_pulse = -1; period_chk = 1'b1;
        repeat (3 * DIV) cyc(1'b0);
        period_chk = 1'b0;
        // R8: back to master clears the flag
        check(aligned_o == 1'b0, "R7", aligned_o, 0);
        frame(1'b1, 1'b1, "R6", 0);
        frame(1'b1, 1'b1, "R6", 0);
        frame(1'b1, 1'b1, "R6", 0);
        cyc(1'b0);
        check(aligned_o == 1'b1, "R6", aligned_o, 1);
        standby_i = 1'b0;
        cyc(1'b0);
        check(aligned_o == 1'b0, "R8", aligned_o, 0);
        period_tag = "R2"; last_pulse = -1; period_chk = 1'b1;
        for (int i = 0; i < 2 * DIV; i++) cyc((i % 7) == 3);
        period_chk = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule